// File: doc/BRIEF.md
# Store-Multiple Transfer Sequencer

This block executes an increment-after store-multiple operation for a 32-bit register machine. A decoded request names a base register, a 16-bit select mask, a writeback flag, a condition-passed flag and an encoding class. The block first vets the request against the legality rules of its class. A legal request with its condition passed reads the base register through a single indexed register-file read port. It then writes one word to memory for each selected register, lowest index first, at ascending word addresses. A final cycle can write the advanced address back into the base register.

A pipeline control stage offers a request whenever `req_ready` is high and holds it for one cycle with `req_valid`. The register file answers combinationally on `rf_data` for the index on `rf_idx`. The memory side is a valid/ready write channel. Completion is signalled by a one-cycle `done`, and a rejected request by a one-cycle `undef`.

Top module: `stm_seq`

## Requirements
- R1: A request is taken only on a cycle with `req_valid` high and `req_ready` high. `req_ready` is high exactly when the sequencer is idle, and `req_valid` while busy has no effect on the stores or on the following results.
- R2: Selected registers are stored in ascending index order. The k-th store (k from 0) goes to address base + 4k, where base is the register-file value of the base register read after acceptance.
- R3: Each store carries the register-file value of its register. While `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady.
- R4: Mask bit 15 (program counter) is stored last, at the highest address, with the `pc_value` captured at acceptance. `done` follows that store by one cycle.
- R5: With writeback on, a base register that is selected but is not the lowest selected index is stored as 32'h0000_0000. A base register that is the lowest selected index is stored with its true value.
- R6: With writeback on, `wb_en` pulses together with `done`, the cycle after the final store handshake, carrying the base index and base + 4 × (number of selected registers). With writeback off, `wb_en` stays low.
- R7: Encoding class T1 (`req_enc` = 1) ignores mask bits 15:8, ignores bit 3 of `req_base`, and always writes back, whatever `req_wback` says.
- R8: An empty effective mask is illegal for every class. Base index 15 is illegal for class A1 (`req_enc` = 0) and class T2 (`req_enc` = 2). `req_enc` = 3 is always illegal.
- R9: For class T2, the mask bits are {P, M, list[13:0]}, with M being the link register (bit 14). The request is illegal if fewer than two bits are set, if bit 13 is set, if bit 15 is set, or if writeback is on and the base register's bit is set.
- R10: An illegal request with its condition passed raises `undef` for exactly the one cycle after acceptance. It produces no store, no `wb_en` and no `done`.
- R11: A request with `req_cond` low, legal or not, produces `done` the cycle after acceptance, with no store, no `wb_en` and no `undef`.
- R12: After reset the block is idle: `req_ready` is high, and `mem_valid`, `wb_en`, `done` and `undef` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_enc | input | 2 | Encoding class: 0 A1, 1 T1, 2 T2, 3 reserved |
| req_base | input | 4 | Base register index |
| req_mask | input | 16 | Register select mask, bit i selects register i |
| req_wback | input | 1 | Write the advanced address back to the base |
| req_cond | input | 1 | Condition passed |
| pc_value | input | DW | Value stored for register 15 |
| rf_idx | output | 4 | Register-file read index |
| rf_data | input | DW | Register-file read data |
| mem_valid | output | 1 | Memory write valid |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | AW | Memory write byte address |
| mem_data | output | DW | Memory write data |
| wb_en | output | 1 | Base register write strobe |
| wb_idx | output | 4 | Base register write index |
| wb_data | output | AW | Base register write value |
| done | output | 1 | Request finished |
| undef | output | 1 | Request rejected as illegal |

## Verification
The bench aims at the base-in-mask cases. A design that always zeroed the base would corrupt the lowest-index store, and one that never zeroed it would leak the register value. It drives the program-counter bit together with stalls on the memory side. A late PC store or an address that moved during a stall would show up as a mismatched store. Each legality rule of the three classes is hit on its own, along with the T1 masking of the upper byte and of base bit 3. A design with a missing or swapped rule would then either emit stores where `undef` is due or reject a legal request. Condition-failed and busy-time requests make sure neither one leaks stores, writeback or `undef`.

// File: rtl/stm_seq.sv
module stm_seq #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_enc,
  input  logic [3:0]    req_base,
  input  logic [15:0]   req_mask,
  input  logic          req_wback,
  input  logic          req_cond,
  input  logic [DW-1:0] pc_value,
  output logic [3:0]    rf_idx,
  input  logic [DW-1:0] rf_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          wb_en,
  output logic [3:0]    wb_idx,
  output logic [AW-1:0] wb_data,
  output logic          done,
  output logic          undef
);
  localparam int NR = 16;
  localparam int PC_IX = NR - 1;
  localparam int SP_IX = 13;
  localparam logic [AW-1:0] STEP = AW'(DW / 8);
  localparam logic [1:0] ENC_A1 = 2'd0;
  localparam logic [1:0] ENC_T1 = 2'd1;
  localparam logic [1:0] ENC_T2 = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_BASE, S_STORE, S_FIN, S_UND} st_t;

  function automatic logic [4:0] ones16(logic [NR-1:0] v);
    ones16 = '0;
    for (int i = 0; i < NR; i++) ones16 = ones16 + 5'(v[i]);
  endfunction

  function automatic logic [3:0] low16(logic [NR-1:0] v);
    low16 = '0;
    for (int i = NR - 1; i >= 0; i--) if (v[i]) low16 = 4'(i);
  endfunction

  st_t            st;
  logic [3:0]     base_q, first_q;
  logic [NR-1:0]  left_q;
  logic           wb_q;
  logic [DW-1:0]  pc_q;
  logic [AW-1:0]  addr_q;

  logic           is_t1, is_t2, bad;
  logic [NR-1:0]  m_eff, rest;
  logic [3:0]     b_eff, cur;
  logic           w_eff;
  logic [4:0]     nsel;

  assign is_t1 = req_enc == ENC_T1;
  assign is_t2 = req_enc == ENC_T2;
  assign m_eff = is_t1 ? {8'h00, req_mask[7:0]} : req_mask;
  assign b_eff = is_t1 ? {1'b0, req_base[2:0]} : req_base;
  assign w_eff = is_t1 | req_wback;
  assign nsel  = ones16(m_eff);

  assign bad = (nsel == 5'd0) || (req_enc == 2'd3)
            || ((req_enc == ENC_A1 || is_t2) && b_eff == 4'(PC_IX))
            || (is_t2 && (nsel < 5'd2 || m_eff[SP_IX] || m_eff[PC_IX]
                          || (w_eff && m_eff[b_eff])));

  assign cur  = low16(left_q);
  assign rest = left_q & (left_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      first_q <= '0;
      left_q  <= '0;
      wb_q    <= 1'b0;
      pc_q    <= '0;
      addr_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          base_q  <= b_eff;
          first_q <= low16(m_eff);
          left_q  <= m_eff;
          wb_q    <= w_eff && req_cond && !bad;
          pc_q    <= pc_value;
          st      <= !req_cond ? S_FIN : (bad ? S_UND : S_BASE);
        end
        S_BASE: begin
          addr_q <= AW'(rf_data);
          st     <= S_STORE;
        end
        S_STORE: if (mem_ready) begin
          left_q <= rest;
          addr_q <= addr_q + STEP;
          if (rest == '0) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = st == S_IDLE;
  assign rf_idx    = (st == S_BASE) ? base_q : cur;
  assign mem_valid = st == S_STORE;
  assign mem_addr  = addr_q;
  assign mem_data  = (cur == 4'(PC_IX)) ? pc_q
                   : (wb_q && cur == base_q && cur != first_q) ? '0 : rf_data;
  assign done      = st == S_FIN;
  assign undef     = st == S_UND;
  assign wb_en     = done && wb_q;
  assign wb_idx    = base_q;
  assign wb_data   = addr_q;

  assert_ready_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || done || undef) |-> !req_ready);

  assert_hold_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (!mem_valid || mem_addr == $past(mem_addr) + STEP));

  assert_pc_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && rf_idx == 4'(PC_IX)) |=> (done && !mem_valid));

  assert_wb_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done && $past(mem_valid && mem_ready)));

  assert_undef_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (!mem_valid && !wb_en && !done));

  assert_undef_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    undef |=> !undef);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/test_stm_seq.sv
module test_stm_seq;
  localparam int DW = 32;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_wback, req_cond;
  logic [1:0] req_enc;
  logic [3:0] req_base, rf_idx, wb_idx;
  logic [15:0] req_mask;
  logic [DW-1:0] pc_value, rf_data, mem_data;
  logic [AW-1:0] mem_addr, wb_data;
  logic mem_valid, mem_ready, wb_en, done, undef;

  logic [31:0] regs [16];
  assign rf_data = regs[rf_idx];

  stm_seq #(.DW(DW), .AW(AW)) i_stm_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_enc(req_enc), .req_base(req_base), .req_mask(req_mask),
    .req_wback(req_wback), .req_cond(req_cond), .pc_value(pc_value),
    .rf_idx(rf_idx), .rf_data(rf_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .done(done), .undef(undef));

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0, stall = 0;
  string cur_tag = "R12", tag = "R12";

  logic [31:0] q_addr[$], q_data[$];
  string q_tag[$];
  bit busy = 0, exp_done = 0, exp_undef = 0, exp_wb = 0;
  bit pend_wb = 0;
  logic [3:0] pend_idx = '0, exp_idx = '0;
  logic [31:0] pend_val = '0, exp_val = '0;
  string wb_tag = "R6";

  task automatic chk(bit ok, string t, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic model_accept();
    bit t1, t2, w, bad;
    logic [15:0] m;
    logic [3:0] b;
    logic [31:0] a;
    int n, low;
    t1 = req_enc == 2'd1;
    t2 = req_enc == 2'd2;
    m  = t1 ? {8'h00, req_mask[7:0]} : req_mask;
    b  = t1 ? {1'b0, req_base[2:0]} : req_base;
    w  = t1 || req_wback;
    n  = $countones(m);
    bad = (n == 0) || (req_enc == 2'd3) || (!t1 && b == 4'd15)
       || (t2 && (n < 2 || m[13] || m[15] || (w && m[b])));
    busy = 1;
    tag = cur_tag;
    if (!req_cond) exp_done = 1;
    else if (bad) exp_undef = 1;
    else begin
      a = regs[b];
      low = -1;
      for (int i = 0; i < 16; i++) begin
        if (m[i]) begin
          if (low < 0) low = i;
          q_addr.push_back(a);
          if (i == 15) begin q_data.push_back(pc_value); q_tag.push_back("R4"); end
          else if (w && i == b && i != low) begin q_data.push_back(32'h0); q_tag.push_back("R5"); end
          else begin q_data.push_back(regs[i]); q_tag.push_back(t1 ? "R7 R3" : "R3"); end
          a = a + 32'd4;
        end
      end
      pend_wb = w; pend_idx = b; pend_val = a;
      wb_tag = t1 ? "R7" : "R6";
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done === exp_done, tag, "done", 32'(done), 32'(exp_done));
      chk(undef === exp_undef, exp_undef ? {tag, " R10"} : tag, "undef", 32'(undef), 32'(exp_undef));
      chk(wb_en === exp_wb, wb_tag, "wb_en", 32'(wb_en), 32'(exp_wb));
      if (exp_wb && wb_en) begin
        chk(wb_idx == exp_idx, wb_tag, "wb_idx", 32'(wb_idx), 32'(exp_idx));
        chk(wb_data == exp_val, wb_tag, "wb_data", wb_data, exp_val);
      end
      chk(req_ready === !busy, "R1", "req_ready", 32'(req_ready), 32'(!busy));
      if (exp_done || exp_undef) busy = 0;
      exp_done = 0; exp_undef = 0; exp_wb = 0;
      if (mem_valid) begin
        if (q_addr.size() == 0) chk(0, tag, "unexpected store", mem_addr, 32'h0);
        else if (mem_ready) begin
          chk(mem_addr == q_addr[0], "R2", "store address", mem_addr, q_addr[0]);
          chk(mem_data == q_data[0], q_tag[0], "store data", mem_data, q_data[0]);
          void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_tag.pop_front());
          if (q_addr.size() == 0) begin
            exp_done = 1; exp_wb = pend_wb; exp_idx = pend_idx; exp_val = pend_val;
          end
        end
      end
      if (req_valid && req_ready) model_accept();
    end
  end

  always @(posedge clk) if (wb_en) regs[wb_idx] <= wb_data;

  always @(posedge clk) begin
    #1;
    mem_ready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<60000 cycles", cycles);
      wrap_up();
    end
  end

  task automatic send(logic [1:0] e, logic [3:0] b, logic [15:0] m, bit w, bit c, string t);
    do begin @(posedge clk); #1; end while (!req_ready);
    req_enc = e; req_base = b; req_mask = m; req_wback = w; req_cond = c;
    pc_value = 32'hC0DE_0000 | 32'(cycles & 16'hFFFF);
    cur_tag = t;
    req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_enc = 0; req_base = 0; req_mask = 0;
    req_wback = 0; req_cond = 0; pc_value = 0; mem_ready = 0;
    for (int i = 0; i < 16; i++) regs[i] = 32'h4000_0000 | (32'(i) << 8) | 32'(i);
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R12", "reset req_ready", 32'(req_ready), 32'h1);
    chk(mem_valid === 1'b0, "R12", "reset mem_valid", 32'(mem_valid), 32'h0);
    chk((done | undef | wb_en) === 1'b0, "R12", "reset strobes", 32'({done, undef, wb_en}), 32'h0);
    @(posedge clk); #1; rst_n = 1;

    send(2'd0, 4'd2, 16'h00F0, 1, 1, "R2 R6");
    send(2'd0, 4'd1, 16'h8005, 0, 1, "R4");
    send(2'd0, 4'd4, 16'h0016, 1, 1, "R5");
    send(2'd0, 4'd1, 16'h0006, 1, 1, "R5");
    send(2'd1, 4'd13, 16'hFF21, 0, 1, "R7");
    send(2'd2, 4'd3, 16'h4101, 1, 1, "R9");
    stall = 1;
    send(2'd0, 4'd0, 16'hFFFF, 0, 1, "R3 R4");
    send(2'd0, 4'd3, 16'h7FFE, 1, 1, "R1");
    repeat (3) begin @(posedge clk); #1; end
    req_enc = 2'd0; req_base = 4'd5; req_mask = 16'h0001; req_cond = 1; req_valid = 1;
    @(posedge clk); #1; req_valid = 0;
    stall = 0;
    send(2'd0, 4'd2, 16'h0000, 1, 1, "R8");
    send(2'd0, 4'd15, 16'h0003, 0, 1, "R8");
    send(2'd3, 4'd1, 16'h0003, 0, 1, "R8");
    send(2'd1, 4'd1, 16'hFF00, 0, 1, "R7 R8");
    send(2'd2, 4'd15, 16'h0003, 0, 1, "R8");
    send(2'd2, 4'd1, 16'h0004, 0, 1, "R9");
    send(2'd2, 4'd1, 16'h2004, 0, 1, "R9");
    send(2'd2, 4'd1, 16'h8004, 0, 1, "R9");
    send(2'd2, 4'd2, 16'h0006, 1, 1, "R9");
    send(2'd2, 4'd2, 16'h0006, 0, 1, "R9");
    send(2'd0, 4'd2, 16'h0000, 1, 0, "R11");
    send(2'd0, 4'd2, 16'h00F0, 1, 0, "R11");
    stall = 1;
    for (int k = 0; k < 40; k++)
      send(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 16'($urandom),
           1'($urandom_range(0, 1)), $urandom_range(0, 7) != 0, "R2 R3");
    do @(negedge clk); while (busy || q_addr.size() != 0);
    repeat (4) @(negedge clk);
    wrap_up();
  end
endmodule